// File: doc/BRIEF.md
# CAN Controller Mode and Status Sequencer

This block decides which operating mode a CAN protocol controller is in and derives the status flags that the host reads. The host writes a control word with three request bits: reset, halt and sleep. The block also receives a strobe for each sampled bit with its bus level, the frame-level indications for bus idle and intermission, and the current transmit and receive error counts. From these it drives a reset-mode flag, error-passive and bus-off flags, a halt/sleep flag, a latched reset-done interrupt, a one-cycle register-clear pulse, and a joined-bus enable for the protocol engine.

The mode machine has six states. ST_RESET is the configuration state, where the block sits after power-on. ST_INIT is the one-cycle re-initialisation step. ST_WAIT counts recessive bits before the block joins the bus. ST_ACTIVE is the on-bus state. ST_HALTED and ST_SLEEP are the parked states.

The transitions are as follows:
- Power-on goes to ST_RESET.
- ST_RESET goes to ST_WAIT when the reset bit is 0.
- ST_WAIT goes to ST_ACTIVE on the eleventh consecutive recessive bit.
- ST_ACTIVE goes to ST_SLEEP, or to ST_HALTED, when a sleep or halt request is pending and the bus is idle or in intermission. Sleep wins if both are pending.
- ST_HALTED goes to ST_ACTIVE when the halt bit is cleared.
- ST_SLEEP goes to ST_ACTIVE when the sleep bit is cleared.
- ST_WAIT, ST_ACTIVE, ST_HALTED and ST_SLEEP all go to ST_INIT when the reset bit is 1.
- ST_INIT always goes to ST_RESET.

Top module: `can_mode_seq`

## Requirements
- R1: After power-on reset, reset_mode is 1, and bus_join, halt_sleep, reset_irq, reg_clear, err_passive and bus_off are all 0.
- R2: A reset bit of 1 seen in an on-bus or waiting state produces exactly one cycle with reg_clear = 1 and reset_mode = 0. In the next cycle reset_mode = 1 and reset_irq = 1. The halt and sleep request bits are cleared during that cycle.
- R3: While the stored reset bit is 1, the block stays in reset mode (reset_mode = 1, bus_join = 0), whatever the bus carries.
- R4: Once the reset bit is written 0, the block needs 11 consecutive strobes with bus_level = 1 (recessive) before it leaves reset mode. bus_join rises and reset_mode falls at the clock edge that samples the eleventh such strobe.
- R5: A strobe with bus_level = 0 (dominant) during the wait sets the recessive count back to zero.
- R6: err_passive is 1 one clock after tec >= 128 or rec >= 128, and 0 one clock after both are below 128.
- R7: bus_off is 1 one clock after tec >= 256. err_passive stays 1 while bus_off is 1.
- R8: A halt or sleep request from the on-bus state takes effect only on a clock where bus_idle or bus_intermission is 1. Until then halt_sleep stays 0 and bus_join stays 1.
- R9: halt_sleep is 1 and bus_join is 0 in both the halted and the sleep state. Sleep is chosen when both request bits are set.
- R10: reset_irq stays set until irq_clr is pulsed, and drops one clock after the pulse.
- R11: Clearing the halt or sleep bit while parked returns the block to bus_join = 1 without another recessive-bit wait.
- R12: A reset bit of 1 written during the recessive-bit wait restarts re-initialisation, and the next wait counts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_rst_req | input | 1 | Reset request bit to write |
| ctl_halt_req | input | 1 | Halt request bit to write |
| ctl_sleep_req | input | 1 | Sleep request bit to write |
| irq_clr | input | 1 | Write-1 clear of reset_irq |
| bit_strobe | input | 1 | One-cycle pulse per sampled bus bit |
| bus_level | input | 1 | Sampled level, 1 = recessive, 0 = dominant |
| bus_idle | input | 1 | Bus is idle |
| bus_intermission | input | 1 | Bus is in intermission |
| tec | input | CNT_W | Transmit error count |
| rec | input | CNT_W | Receive error count |
| reset_mode | output | 1 | Reset/configuration mode status |
| err_passive | output | 1 | Error-passive status, also set during bus-off |
| bus_off | output | 1 | Bus-off status |
| halt_sleep | output | 1 | Halted or sleeping status |
| reset_irq | output | 1 | Latched reset-done interrupt |
| reg_clear | output | 1 | One-cycle register-clear pulse |
| bus_join | output | 1 | Enable for the protocol engine to take part on the bus |

## Verification
A control write is registered at the first clock edge after it is driven, and the mode reacts at the second edge. The bench therefore waits two edges before it checks a mode change caused by a write. The error flags and the irq clear each take one edge, while the join decision lands on the same edge that samples the eleventh recessive strobe. Inputs change on the falling clock edge and outputs are read on a later falling edge, after exactly the number of rising edges listed above. The reset sequence is checked edge by edge: first the reg_clear cycle, then the cycle where reset_mode and reset_irq are both 1.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_RESET,
        ST_WAIT,
        ST_ACTIVE,
        ST_HALTED,
        ST_SLEEP
    } mode_e;

    typedef enum logic [1:0] {
        ERR_ACTIVE,
        ERR_PASSIVE,
        ERR_BUSOFF
    } err_e;

endpackage

// File: rtl/can_join_counter.sv
module can_join_counter #(
    parameter int JOIN_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic strobe,
    input  logic level,
    output logic done
);
    localparam int CW = $clog2(JOIN_BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(JOIN_BITS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en) begin
            cnt_q <= '0;
        end else if (strobe) begin
            if (!level || cnt_q == LAST) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign done = en && strobe && level && (cnt_q == LAST);

    AST_DOMINANT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && strobe && !level) |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/can_err_classify.sv
module can_err_classify
    import can_mode_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int PASSIVE_LIM = 128,
    parameter int BUSOFF_LIM  = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] tec,
    input  logic [CNT_W-1:0] rec,
    output logic             err_passive,
    output logic             bus_off
);
    localparam logic [CNT_W-1:0] P_LIM = CNT_W'(PASSIVE_LIM);
    localparam logic [CNT_W-1:0] B_LIM = CNT_W'(BUSOFF_LIM);

    err_e err_q, err_d;

    always_comb begin
        if (tec >= B_LIM) begin
            err_d = ERR_BUSOFF;
        end else if (tec >= P_LIM || rec >= P_LIM) begin
            err_d = ERR_PASSIVE;
        end else begin
            err_d = ERR_ACTIVE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= ERR_ACTIVE;
        end else if (clr) begin
            err_q <= ERR_ACTIVE;
        end else begin
            err_q <= err_d;
        end
    end

    assign err_passive = (err_q != ERR_ACTIVE);
    assign bus_off     = (err_q == ERR_BUSOFF);

    AST_PASSIVE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((tec >= P_LIM || rec >= P_LIM) && !clr) |=> err_passive); // R6

    AST_BUSOFF_KEEPS_PASSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((tec >= B_LIM) && !clr) |=> (bus_off && err_passive)); // R7

endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
    import can_mode_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int JOIN_BITS   = 11,
    parameter int PASSIVE_LIM = 128,
    parameter int BUSOFF_LIM  = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             ctl_rst_req,
    input  logic             ctl_halt_req,
    input  logic             ctl_sleep_req,
    input  logic             irq_clr,
    input  logic             bit_strobe,
    input  logic             bus_level,
    input  logic             bus_idle,
    input  logic             bus_intermission,
    input  logic [CNT_W-1:0] tec,
    input  logic [CNT_W-1:0] rec,
    output logic             reset_mode,
    output logic             err_passive,
    output logic             bus_off,
    output logic             halt_sleep,
    output logic             reset_irq,
    output logic             reg_clear,
    output logic             bus_join
);
    mode_e state_q, state_d;
    logic  rst_req_q, halt_req_q, sleep_req_q;
    logic  join_done;
    logic  bus_gap;

    assign bus_gap = bus_idle || bus_intermission;

    can_join_counter #(
        .JOIN_BITS(JOIN_BITS)
    ) u_join (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (state_q == ST_WAIT),
        .strobe (bit_strobe),
        .level  (bus_level),
        .done   (join_done)
    );

    can_err_classify #(
        .CNT_W       (CNT_W),
        .PASSIVE_LIM (PASSIVE_LIM),
        .BUSOFF_LIM  (BUSOFF_LIM)
    ) u_err (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (reg_clear),
        .tec         (tec),
        .rec         (rec),
        .err_passive (err_passive),
        .bus_off     (bus_off)
    );

    // Host control word; the re-initialisation cycle drops parking requests.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req_q   <= 1'b1;
            halt_req_q  <= 1'b0;
            sleep_req_q <= 1'b0;
        end else if (state_q == ST_INIT) begin
            halt_req_q  <= 1'b0;
            sleep_req_q <= 1'b0;
        end else if (ctl_we) begin
            rst_req_q   <= ctl_rst_req;
            halt_req_q  <= ctl_halt_req;
            sleep_req_q <= ctl_sleep_req;
        end
    end

    // Reset-done interrupt: set by re-initialisation, cleared by host.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reset_irq <= 1'b0;
        end else if (state_q == ST_INIT) begin
            reset_irq <= 1'b1;
        end else if (irq_clr) begin
            reset_irq <= 1'b0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT: begin
                state_d = ST_RESET;
            end
            ST_RESET: begin
                if (!rst_req_q) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (rst_req_q)      state_d = ST_INIT;
                else if (join_done) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (rst_req_q) begin
                    state_d = ST_INIT;
                end else if ((halt_req_q || sleep_req_q) && bus_gap) begin
                    state_d = sleep_req_q ? ST_SLEEP : ST_HALTED;
                end
            end
            ST_HALTED: begin
                if (rst_req_q)        state_d = ST_INIT;
                else if (!halt_req_q) state_d = ST_ACTIVE;
            end
            ST_SLEEP: begin
                if (rst_req_q)         state_d = ST_INIT;
                else if (!sleep_req_q) state_d = ST_ACTIVE;
            end
            default: begin
                state_d = ST_INIT;
            end
        endcase
    end

    // Output decode
    always_comb begin
        reset_mode = 1'b0;
        halt_sleep = 1'b0;
        reg_clear  = 1'b0;
        bus_join   = 1'b0;
        unique case (state_q)
            ST_INIT:   reg_clear  = 1'b1;
            ST_RESET:  reset_mode = 1'b1;
            ST_WAIT:   reset_mode = 1'b1;
            ST_ACTIVE: bus_join   = 1'b1;
            ST_HALTED: halt_sleep = 1'b1;
            ST_SLEEP:  halt_sleep = 1'b1;
            default:   reg_clear  = 1'b1;
        endcase
    end

    AST_INIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_clear |=> (!reg_clear && reset_mode && reset_irq)); // R2

    AST_HOLD_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_q && state_q == ST_RESET) |=> (reset_mode && !bus_join)); // R3

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !rst_req_q && !join_done) |=> (state_q == ST_WAIT)); // R4

    AST_PARK_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_sleep) |-> $past(bus_gap)); // R8

    AST_PARK_OFF_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        halt_sleep |-> !bus_join); // R9

endmodule

// File: tb/sim_can_mode_seq.sv
`timescale 1ns/1ps
module sim_can_mode_seq;
    localparam int CNT_W = 9;

    typedef struct packed {
        logic [CNT_W-1:0] t;
        logic [CNT_W-1:0] r;
        logic             p;
        logic             o;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{9'd0,   9'd0,   1'b0, 1'b0},
        '{9'd127, 9'd127, 1'b0, 1'b0},
        '{9'd128, 9'd0,   1'b1, 1'b0},
        '{9'd0,   9'd128, 1'b1, 1'b0},
        '{9'd255, 9'd10,  1'b1, 1'b0},
        '{9'd256, 9'd0,   1'b1, 1'b1},
        '{9'd511, 9'd255, 1'b1, 1'b1},
        '{9'd100, 9'd200, 1'b1, 1'b0},
        '{9'd0,   9'd0,   1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_we = 1'b0, ctl_rst_req = 1'b0, ctl_halt_req = 1'b0, ctl_sleep_req = 1'b0;
    logic irq_clr = 1'b0, bit_strobe = 1'b0, bus_level = 1'b1;
    logic bus_idle = 1'b1, bus_intermission = 1'b0;
    logic [CNT_W-1:0] tec = '0, rec = '0;
    logic reset_mode, err_passive, bus_off, halt_sleep, reset_irq, reg_clear, bus_join;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    can_mode_seq u0 (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_rst_req(ctl_rst_req),
        .ctl_halt_req(ctl_halt_req), .ctl_sleep_req(ctl_sleep_req),
        .irq_clr(irq_clr), .bit_strobe(bit_strobe), .bus_level(bus_level),
        .bus_idle(bus_idle), .bus_intermission(bus_intermission),
        .tec(tec), .rec(rec),
        .reset_mode(reset_mode), .err_passive(err_passive), .bus_off(bus_off),
        .halt_sleep(halt_sleep), .reset_irq(reset_irq), .reg_clear(reg_clear),
        .bus_join(bus_join)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic r, input logic h, input logic s);
        ctl_we = 1'b1; ctl_rst_req = r; ctl_halt_req = h; ctl_sleep_req = s;
        tick();
        ctl_we = 1'b0;
    endtask

    task automatic strobe(input logic lvl);
        bit_strobe = 1'b1; bus_level = lvl;
        tick();
        bit_strobe = 1'b0; bus_level = 1'b1;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 power-on state
        chk(reset_mode,  1'b1, "R1 reset_mode");
        chk(bus_join,    1'b0, "R1 bus_join");
        chk(halt_sleep,  1'b0, "R1 halt_sleep");
        chk(reset_irq,   1'b0, "R1 reset_irq");
        chk(reg_clear,   1'b0, "R1 reg_clear");
        chk(err_passive, 1'b0, "R1 err_passive");
        chk(bus_off,     1'b0, "R1 bus_off");

        // R3: recessive traffic while the reset bit is still 1
        for (int i = 0; i < 14; i++) strobe(1'b1);
        chk(reset_mode, 1'b1, "R3 reset_mode held");
        chk(bus_join,   1'b0, "R3 bus_join held low");

        // R4/R5: clear reset bit, then a dominant bit mid-count
        wr(1'b0, 1'b0, 1'b0);
        tick();
        for (int i = 0; i < 5; i++) strobe(1'b1);
        strobe(1'b0);
        for (int i = 0; i < 10; i++) strobe(1'b1);
        chk(bus_join,   1'b0, "R5 count restarted after dominant");
        chk(reset_mode, 1'b1, "R5 still in reset mode");
        strobe(1'b1);
        chk(bus_join,   1'b1, "R4 join on eleventh recessive");
        chk(reset_mode, 1'b0, "R4 reset_mode cleared");

        // R6/R7: error-count table
        for (int i = 0; i < NV; i++) begin
            tec = VEC[i].t;
            rec = VEC[i].r;
            tick();
            chk(err_passive, VEC[i].p, $sformatf("R6 err_passive vec %0d", i));
            chk(bus_off,     VEC[i].o, $sformatf("R7 bus_off vec %0d", i));
        end

        // R8: halt deferred while bus is busy
        bus_idle = 1'b0; bus_intermission = 1'b0;
        wr(1'b0, 1'b1, 1'b0);
        tick();
        tick();
        chk(halt_sleep, 1'b0, "R8 halt deferred");
        chk(bus_join,   1'b1, "R8 still joined");
        bus_intermission = 1'b1;
        tick();
        chk(halt_sleep, 1'b1, "R9 halted in intermission");
        chk(bus_join,   1'b0, "R9 not joined while halted");

        // R11: un-halt returns without a wait
        bus_intermission = 1'b0;
        wr(1'b0, 1'b0, 1'b0);
        tick();
        chk(halt_sleep, 1'b0, "R11 halt_sleep cleared");
        chk(bus_join,   1'b1, "R11 rejoined");
        chk(reset_mode, 1'b0, "R11 no reset mode");

        // R9: sleep wins when both bits are set
        bus_idle = 1'b1;
        wr(1'b0, 1'b1, 1'b1);
        tick();
        chk(halt_sleep, 1'b1, "R9 sleep halt_sleep");
        chk(bus_join,   1'b0, "R9 sleep not joined");
        wr(1'b0, 1'b1, 1'b0);
        tick();
        chk(bus_join,   1'b1, "R11 woke from sleep");
        chk(halt_sleep, 1'b0, "R9 sleep chosen over halt");
        wr(1'b0, 1'b0, 1'b0);
        tick();

        // R2: reset request from on-bus
        wr(1'b1, 1'b0, 1'b0);
        tick();
        chk(reg_clear,  1'b1, "R2 reg_clear pulse");
        chk(reset_mode, 1'b0, "R2 reset_mode during init");
        chk(bus_join,   1'b0, "R2 left bus");
        tick();
        chk(reg_clear,  1'b0, "R2 reg_clear one cycle");
        chk(reset_mode, 1'b1, "R2 reset_mode set");
        chk(reset_irq,  1'b1, "R2 reset_irq set");

        // R10: irq write-1-clear
        tick();
        chk(reset_irq, 1'b1, "R10 irq held");
        irq_clr = 1'b1;
        tick();
        irq_clr = 1'b0;
        chk(reset_irq, 1'b0, "R10 irq cleared");

        // R12: reset request during the wait restarts the count
        wr(1'b0, 1'b0, 1'b0);
        tick();
        for (int i = 0; i < 6; i++) strobe(1'b1);
        wr(1'b1, 1'b0, 1'b0);
        tick();
        chk(reg_clear, 1'b1, "R12 init from wait");
        tick();
        chk(reset_irq, 1'b1, "R12 irq set again");
        wr(1'b0, 1'b0, 1'b0);
        tick();
        for (int i = 0; i < 10; i++) strobe(1'b1);
        chk(bus_join, 1'b0, "R12 count restarted from zero");
        strobe(1'b1);
        chk(bus_join, 1'b1, "R12 joined after eleven");

        finish_run();
    end
endmodule